// File: doc/BRIEF.md
# Multi-Channel Capture/Compare Timer

A timer peripheral in which one 16-bit count register, advanced by a selectable count source, is shared by three capture/compare channels. The count source is one of six options: the system clock undivided, divided by 4 or by 12, single-cycle strobes from an overflow elsewhere on the chip, rising edges of an external count pin, or rising edges of an external oscillator divided by 8. Asynchronous sources are synchronized, and each source event becomes a one-cycle enable on the system clock.

Each channel is set through a small word-wide register bus to one of five modes. In capture mode it latches the count on a chosen pin edge. In compare mode it raises a flag on a match. In toggle mode it also flips its output pin on a match. In PWM mode it drives an 8- to 16-bit pulse-width signal from a reload register. In frequency mode it drives a square wave with a programmable half-period. Channel 2 comes out of reset as a running watchdog. Software keeps it from firing by writing the channel's value register. A single write turns it off, and only a reset turns it back on.

Top module: `pca_timer`

## Requirements
- R1: After reset the count is 0, CTRL (addr 0) reads 0x0008 (source 0 = system clock / 12, run bit 3 set), FLAGS (addr 2) reads 0, WDCTRL (addr 3) reads 0xFF01 (offset 0xFF in bits 15:8, enable bit 0), and all channel outputs, flags and the watchdog reset are low.
- R2: CTRL bits 2:0 select the count source: 0 = clock/12, 1 = clock/4, 2 = timer-0 strobe, 3 = external count pin rising edge, 4 = every clock, 5 = every 8th external oscillator rising edge. The count advances by exactly one per source event while the run bit is set.
- R3: When the count steps from 0xFFFF to 0x0000 the overflow flag (FLAGS bit 3, pin `ovf_flag_o`) is set.
- R4: In capture mode (MODE bits 2:0 = 1), a synchronized rising edge (enabled by MODE bit 3) or falling edge (enabled by MODE bit 4) on the channel input copies the count into VAL and sets the channel flag. A disabled edge leaves VAL and the flag unchanged.
- R5: In compare mode (mode 2), the channel flag (FLAGS bit n) is set in the cycle the count becomes equal to VAL, and the output pin does not change.
- R6: In toggle mode (mode 3), the output pin inverts in the same cycle the flag is set by a match.
- R7: In PWM mode (mode 4), MODE bits 7:5 select 8, 9, 10, 11 bits (0..3) or 16 bits (4). The output falls when the low N bits of the count roll over to zero, and rises when they equal the low N bits of the reload value. VAL is copied into the active compare only at rollover, so a nonzero value D gives 2^N - D high counts per period.
- R8: In frequency mode (mode 5), each time the count's low byte equals VAL[7:0] the output toggles and VAL[7:0] increases by VAL[15:8], giving a half-period of VAL[15:8] counts.
- R9: Writing 1 to a FLAGS bit clears that flag. If a hardware set falls in the same cycle, the set wins.
- R10: While the watchdog is enabled, a write to channel 2's VAL (addr 10) reloads the match point to the count's high byte plus the offset. When the high byte equals the match point, `wd_rst_o` rises and stays high until reset.
- R11: Writing WDCTRL with bit 0 clear disables the watchdog. Later writes with bit 0 set do not re-enable it, and no watchdog reset follows.
- R12: A write to COUNT (addr 1) loads the written value even in a cycle where the source would advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| t0_ovf_i | input | 1 | One-cycle overflow strobe from timer 0 |
| ext_cnt_i | input | 1 | Asynchronous external count pin |
| ext_osc_i | input | 1 | External oscillator, sampled as data |
| cap_i | input | 3 | Per-channel capture inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| ch_out_o | output | 3 | Per-channel output pins |
| ch_flag_o | output | 3 | Per-channel interrupt flags |
| ovf_flag_o | output | 1 | Count overflow flag |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
A software flag clear and a hardware compare match can land on the same clock edge. The bench starts the count from a known value and waits until the count is one short of the compare value. It then issues the FLAGS write so that the write is taken on the very edge at which the match occurs. The flag must read set afterwards. A second clear with no match pending must then read it as zero. The count-register write is tested the same way, against a source tick on the same edge.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int CNT_W  = 16;
    localparam int NCH    = 3;
    localparam int AW     = 4;
    localparam int DW     = 16;
    localparam int WD_CH  = 2;

    localparam logic [AW-1:0] A_CTRL  = 4'd0;
    localparam logic [AW-1:0] A_CNT   = 4'd1;
    localparam logic [AW-1:0] A_FLAG  = 4'd2;
    localparam logic [AW-1:0] A_WD    = 4'd3;
    localparam logic [AW-1:0] A_MODE0 = 4'd4;
    localparam logic [AW-1:0] A_VAL0  = 4'd8;

    typedef enum logic [2:0] {
        SRC_SYS12 = 3'd0,
        SRC_SYS4  = 3'd1,
        SRC_T0    = 3'd2,
        SRC_EXT   = 3'd3,
        SRC_SYS   = 3'd4,
        SRC_OSC8  = 3'd5
    } src_e;

    typedef enum logic [2:0] {
        M_OFF = 3'd0,
        M_CAP = 3'd1,
        M_SWT = 3'd2,
        M_HSO = 3'd3,
        M_PWM = 3'd4,
        M_FRQ = 3'd5
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [1:0]         edg;    // bit0 rising, bit1 falling
        logic [2:0]         wsel;
        logic [CNT_W-1:0]   val;
        logic [CNT_W-1:0]   act;
        logic               out;
        logic               flag;
        logic [1:0]         sy;
        logic               prev;
    } chan_st_t;

    typedef struct packed {
        logic               en;
        logic [7:0]         offs;
        logic [7:0]         match;
        logic               fire;
    } wd_st_t;

    typedef struct packed {
        src_e               src;
        logic               run;
        logic [CNT_W-1:0]   cnt;
        logic               ovf;
    } base_st_t;

    function automatic logic [CNT_W-1:0] pwm_mask(input logic [2:0] w);
        case (w)
            3'd0:    pwm_mask = 16'h00FF;
            3'd1:    pwm_mask = 16'h01FF;
            3'd2:    pwm_mask = 16'h03FF;
            3'd3:    pwm_mask = 16'h07FF;
            default: pwm_mask = 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/pca_tick_gen.sv
module pca_tick_gen
    import pca_pkg::*;
#(
    parameter int DIV_A   = 12,
    parameter int DIV_B   = 4,
    parameter int OSC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  src_e src_i,
    input  logic t0_ovf_i,
    input  logic ext_cnt_i,
    input  logic ext_osc_i,
    output logic tick_o
);

    localparam int DAW = $clog2(DIV_A);
    localparam int DBW = $clog2(DIV_B);
    localparam int OW  = $clog2(OSC_DIV);

    typedef struct packed {
        logic [DAW-1:0] diva;
        logic [DBW-1:0] divb;
        logic [2:0]     esy;
        logic [2:0]     osy;
        logic [OW-1:0]  odiv;
    } tick_st_t;

    tick_st_t s_d, s_q;
    logic e_edge, o_edge, o_pulse, raw;

    always_comb begin
        s_d     = s_q;
        e_edge  = s_q.esy[1] & ~s_q.esy[2];
        o_edge  = s_q.osy[1] & ~s_q.osy[2];
        o_pulse = o_edge && (s_q.odiv == OW'(OSC_DIV - 1));

        s_d.diva = (s_q.diva == DAW'(DIV_A - 1)) ? '0 : s_q.diva + 1'b1;
        s_d.divb = (s_q.divb == DBW'(DIV_B - 1)) ? '0 : s_q.divb + 1'b1;
        s_d.esy  = {s_q.esy[1:0], ext_cnt_i};
        s_d.osy  = {s_q.osy[1:0], ext_osc_i};
        if (o_edge) begin
            s_d.odiv = s_q.odiv + 1'b1;
        end

        case (src_i)
            SRC_SYS12: raw = (s_q.diva == DAW'(DIV_A - 1));
            SRC_SYS4:  raw = (s_q.divb == DBW'(DIV_B - 1));
            SRC_T0:    raw = t0_ovf_i;
            SRC_EXT:   raw = e_edge;
            SRC_SYS:   raw = 1'b1;
            SRC_OSC8:  raw = o_pulse;
            default:   raw = 1'b0;
        endcase
        tick_o = run_i & raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.diva < DAW'(DIV_A));

    // R2
    div_b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.divb == DBW'(DIV_B - 1)) |=> (s_q.divb == '0));

endmodule

// File: rtl/pca_channel.sv
module pca_channel
    import pca_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] cnt_inc_i,
    input  logic             blocked_i,
    input  logic             mode_we_i,
    input  logic             val_we_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             flag_clr_i,
    output logic [7:0]       mode_o,
    output logic [CNT_W-1:0] val_o,
    output logic             out_o,
    output logic             flag_o
);

    chan_st_t s_d, s_q;
    logic rise, fall;
    logic [CNT_W-1:0] mask, low;

    always_comb begin
        s_d      = s_q;
        rise     = s_q.sy[1] & ~s_q.prev;
        fall     = ~s_q.sy[1] & s_q.prev;
        mask     = pwm_mask(s_q.wsel);
        low      = cnt_inc_i & mask;
        s_d.sy   = {s_q.sy[0], cap_i};
        s_d.prev = s_q.sy[1];

        if (mode_we_i) begin
            s_d.mode = mode_e'(wdata_i[2:0]);
            s_d.edg  = wdata_i[4:3];
            s_d.wsel = wdata_i[7:5];
        end
        if (val_we_i) begin
            s_d.val = wdata_i;
        end
        if (flag_clr_i) begin
            s_d.flag = 1'b0;
        end

        if (!blocked_i) begin
            case (s_q.mode)
                M_CAP: begin
                    if ((rise && s_q.edg[0]) || (fall && s_q.edg[1])) begin
                        s_d.val  = cnt_q_i;
                        s_d.flag = 1'b1;
                    end
                end
                M_SWT, M_HSO: begin
                    if (tick_i && (cnt_inc_i == s_q.val)) begin
                        s_d.flag = 1'b1;
                        if (s_q.mode == M_HSO) begin
                            s_d.out = ~s_q.out;
                        end
                    end
                end
                M_PWM: begin
                    if (tick_i) begin
                        if (low == '0) begin
                            s_d.out = 1'b0;
                            s_d.act = s_q.val;
                        end else if (low == (s_q.act & mask)) begin
                            s_d.out  = 1'b1;
                            s_d.flag = 1'b1;
                        end
                    end
                end
                M_FRQ: begin
                    if (tick_i && (cnt_inc_i[7:0] == s_q.val[7:0])) begin
                        s_d.out      = ~s_q.out;
                        s_d.val[7:0] = s_q.val[7:0] + s_q.val[15:8];
                        s_d.flag     = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        mode_o = {s_q.wsel, s_q.edg, s_q.mode};
        val_o  = s_q.val;
        out_o  = s_q.out;
        flag_o = s_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7
    pwm_roll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !blocked_i && s_q.mode == M_PWM && low == '0) |=> !out_o);

    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !blocked_i && s_q.mode == M_SWT && cnt_inc_i == s_q.val) |=> flag_o);

    // R5
    swt_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == M_SWT && !mode_we_i) |=> $stable(out_o));

endmodule

// File: rtl/pca_watchdog.sv
module pca_watchdog #(
    parameter logic [7:0] OFFS_RST = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cnt_hi_i,
    input  logic       ctl_we_i,
    input  logic       ctl_en_i,
    input  logic [7:0] ctl_offs_i,
    input  logic       kick_i,
    output logic       en_o,
    output logic [7:0] offs_o,
    output logic       fire_o
);

    import pca_pkg::*;

    wd_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ctl_we_i) begin
            s_d.offs = ctl_offs_i;
            if (!ctl_en_i) begin
                s_d.en = 1'b0;
            end
        end
        if (s_q.en && kick_i) begin
            s_d.match = cnt_hi_i + s_q.offs;
        end else if (s_q.en && (cnt_hi_i == s_q.match)) begin
            s_d.fire = 1'b1;
        end
        en_o   = s_q.en;
        offs_o = s_q.offs;
        fire_o = s_q.fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en    <= 1'b1;
            s_q.offs  <= OFFS_RST;
            s_q.match <= OFFS_RST;
            s_q.fire  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R11
    wd_stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> !en_o);

    // R11
    wd_no_fire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !fire_o) |=> !fire_o);

    // R10
    wd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> fire_o);

endmodule

// File: rtl/pca_timer.sv
module pca_timer
    import pca_pkg::*;
#(
    parameter logic [7:0] WD_OFFS_RST = 8'hFF,
    parameter int         DIV_A       = 12,
    parameter int         DIV_B       = 4,
    parameter int         OSC_DIV     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           t0_ovf_i,
    input  logic           ext_cnt_i,
    input  logic           ext_osc_i,
    input  logic [NCH-1:0] cap_i,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [DW-1:0]  wr_data_i,
    input  logic [AW-1:0]  rd_addr_i,
    output logic [DW-1:0]  rd_data_o,
    output logic [NCH-1:0] ch_out_o,
    output logic [NCH-1:0] ch_flag_o,
    output logic           ovf_flag_o,
    output logic           wd_rst_o
);

    base_st_t s_d, s_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_inc;
    logic             cnt_we, kick, wd_en;
    logic [7:0]       wd_offs;
    logic [7:0]       ch_mode [NCH];
    logic [CNT_W-1:0] ch_val  [NCH];

    assign cnt_inc = s_q.cnt + 1'b1;
    assign cnt_we  = wr_en_i && (wr_addr_i == A_CNT);
    assign kick    = wr_en_i && (wr_addr_i == AW'(A_VAL0 + WD_CH));

    pca_tick_gen #(
        .DIV_A   (DIV_A),
        .DIV_B   (DIV_B),
        .OSC_DIV (OSC_DIV)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (s_q.run),
        .src_i     (s_q.src),
        .t0_ovf_i  (t0_ovf_i),
        .ext_cnt_i (ext_cnt_i),
        .ext_osc_i (ext_osc_i),
        .tick_o    (tick)
    );

    pca_watchdog #(
        .OFFS_RST (WD_OFFS_RST)
    ) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_hi_i   (s_q.cnt[15:8]),
        .ctl_we_i   (wr_en_i && (wr_addr_i == A_WD)),
        .ctl_en_i   (wr_data_i[0]),
        .ctl_offs_i (wr_data_i[15:8]),
        .kick_i     (kick),
        .en_o       (wd_en),
        .offs_o     (wd_offs),
        .fire_o     (wd_rst_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam bit IS_WD = (i == WD_CH);
        logic blocked;
        assign blocked = IS_WD && wd_en;

        pca_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cap_i      (cap_i[i]),
            .tick_i     (tick),
            .cnt_q_i    (s_q.cnt),
            .cnt_inc_i  (cnt_inc),
            .blocked_i  (blocked),
            .mode_we_i  (wr_en_i && (wr_addr_i == AW'(A_MODE0 + i))),
            .val_we_i   (wr_en_i && (wr_addr_i == AW'(A_VAL0 + i)) && !blocked),
            .wdata_i    (wr_data_i),
            .flag_clr_i (wr_en_i && (wr_addr_i == A_FLAG) && wr_data_i[i]),
            .mode_o     (ch_mode[i]),
            .val_o      (ch_val[i]),
            .out_o      (ch_out_o[i]),
            .flag_o     (ch_flag_o[i])
        );
    end

    always_comb begin
        s_d = s_q;
        if (wr_en_i && (wr_addr_i == A_CTRL)) begin
            s_d.src = src_e'(wr_data_i[2:0]);
            s_d.run = wr_data_i[3];
        end
        if (wr_en_i && (wr_addr_i == A_FLAG) && wr_data_i[3]) begin
            s_d.ovf = 1'b0;
        end
        if (tick) begin
            s_d.cnt = cnt_inc;
            if (s_q.cnt == '1) begin
                s_d.ovf = 1'b1;
            end
        end
        if (cnt_we) begin
            s_d.cnt = wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL: rd_data_o = {12'h000, s_q.run, s_q.src};
            A_CNT:  rd_data_o = s_q.cnt;
            A_FLAG: rd_data_o = {12'h000, s_q.ovf, ch_flag_o};
            A_WD:   rd_data_o = {wd_offs, 7'h00, wd_en};
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr_i == AW'(A_MODE0 + i)) rd_data_o = {8'h00, ch_mode[i]};
            if (rd_addr_i == AW'(A_VAL0 + i))  rd_data_o = ch_val[i];
        end
    end

    assign ovf_flag_o = s_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.src <= SRC_SYS12;
            s_q.run <= 1'b1;
            s_q.cnt <= '0;
            s_q.ovf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> (s_q.cnt == $past(s_q.cnt) + 16'd1));

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.cnt == 16'hFFFF) |=> ovf_flag_o);

    // R12
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (s_q.cnt == $past(wr_data_i)));

    // R2
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(s_q.cnt));

endmodule

// File: tb/pca_timer_bench.sv
module pca_timer_bench;
    import pca_pkg::*;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           t0_ovf = 1'b0;
    logic           ext_cnt = 1'b0;
    logic           ext_osc = 1'b0;
    logic [2:0]     cap = 3'b000;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [15:0]    wr_data = '0;
    logic [3:0]     rd_addr = '0;
    logic [15:0]    rd_data;
    logic [2:0]     ch_out, ch_flag;
    logic           ovf_flag, wd_rst;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pca_timer u_pca_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .t0_ovf_i   (t0_ovf),
        .ext_cnt_i  (ext_cnt),
        .ext_osc_i  (ext_osc),
        .cap_i      (cap),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .ch_out_o   (ch_out),
        .ch_flag_o  (ch_flag),
        .ovf_flag_o (ovf_flag),
        .wd_rst_o   (wd_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    task automatic halt();
        wr(A_CTRL, 16'h0004);
    endtask

    task automatic go();
        wr(A_CTRL, 16'h000C);
    endtask

    function automatic int pwm_high(input int n, input int d);
        int m;
        m = d % (1 << n);
        return (m == 0) ? 0 : (1 << n) - m;
    endfunction

    task automatic src_test(input logic [2:0] src, input int kind, input int k);
        logic [15:0] c0, c1;
        wr(A_CTRL, {12'h000, 1'b1, src});
        wait_n(8);
        rd(A_CNT, c0);
        case (kind)
            0: wait_n(12 * k);
            1: wait_n(4 * k);
            2: for (int i = 0; i < k; i++) begin
                   t0_ovf = 1'b1; wait_n(1); t0_ovf = 1'b0; wait_n(2);
               end
            3: for (int i = 0; i < k; i++) begin
                   ext_cnt = 1'b1; wait_n(4); ext_cnt = 1'b0; wait_n(4);
               end
            default: for (int i = 0; i < 8 * k; i++) begin
                   ext_osc = 1'b1; wait_n(2); ext_osc = 1'b0; wait_n(2);
               end
        endcase
        if (kind >= 2) wait_n(6);
        if (kind == 0) begin
            rd(A_CNT, c1);
        end else begin
            rd(A_CNT, c1);
        end
        check($sformatf("R2 src%0d", src), 32'(c1 - c0), 32'(k));
    endtask

    task automatic cmp_test(input int v);
        logic o1;
        halt();
        wr(A_MODE0, 16'h0002);
        wr(A_MODE0 + 4'd1, 16'h0003);
        wr(A_VAL0, 16'(v));
        wr(A_VAL0 + 4'd1, 16'(v));
        wr(A_CNT, 16'h0000);
        wr(A_FLAG, 16'h000F);
        o1 = ch_out[1];
        go();
        wait_n(v - 1);
        check("R5 no early flag", {29'd0, ch_flag}, 32'd0);
        check("R6 no early toggle", ch_out[1], o1);
        wait_n(1);
        check("R5 flag on match", ch_flag[0], 1'b1);
        check("R5 out held", ch_out[0], 1'b0);
        check("R6 toggle on match", {ch_out[1], ch_flag[1]}, {~o1, 1'b1});
    endtask

    task automatic pwm_test(input int w, input int d);
        int n, hi;
        n = 8 + w;
        halt();
        wr(A_MODE0 + 4'd1, 16'(4 | (w << 5)));
        wr(A_VAL0 + 4'd1, 16'(d));
        wr(A_CNT, 16'h0000);
        go();
        wait_n(1 << n);
        hi = 0;
        for (int i = 0; i < (1 << n); i++) begin
            if (ch_out[1]) hi++;
            wait_n(1);
        end
        check($sformatf("R7 pwm N=%0d D=%0d", n, d), 32'(hi), 32'(pwm_high(n, d)));
    endtask

    task automatic frq_test(input int h, input int l);
        int last, ntog;
        logic prev;
        halt();
        wr(A_MODE0, 16'h0005);
        wr(A_VAL0, {8'(h), 8'(l)});
        wr(A_CNT, 16'h0000);
        go();
        last = -1; ntog = 0; prev = ch_out[0];
        for (int c = 0; c < 700 && ntog < 3; c++) begin
            wait_n(1);
            if (ch_out[0] !== prev) begin
                prev = ch_out[0];
                if (last >= 0) check("R8 half period", 32'(c - last), 32'(h));
                last = c;
                ntog++;
            end
        end
        check("R8 toggle count", 32'(ntog), 32'd3);
    endtask

    initial begin
        logic [15:0] d;
        int m;
        void'($urandom(32'd4242));
        do_reset();

        // R1 reset state
        rd(A_CNT, d);  check("R1 count", d, 16'h0000);
        rd(A_CTRL, d); check("R1 ctrl", d, 16'h0008);
        rd(A_FLAG, d); check("R1 flags", d, 16'h0000);
        rd(A_WD, d);   check("R1 wdctrl", d, 16'hFF01);
        check("R1 pins", {ch_out, ch_flag, ovf_flag, wd_rst}, 8'h00);

        wr(A_WD, 16'hFF00);

        // R2 count sources
        src_test(3'd0, 0, 10);
        src_test(3'd1, 1, 10);
        src_test(3'd2, 2, 7);
        src_test(3'd3, 3, 5);
        src_test(3'd5, 5, 3);

        // R12 count write beats a tick
        go();
        wr(A_CNT, 16'h1234);
        rd(A_CNT, d); check("R12 write wins", d, 16'h1234);

        // R3 overflow
        halt();
        wr(A_CNT, 16'hFFFE);
        wr(A_FLAG, 16'h000F);
        go();
        wait_n(1);
        check("R3 before wrap", ovf_flag, 1'b0);
        wait_n(1);
        rd(A_CNT, d); check("R3 wrapped", d, 16'h0000);
        rd(A_FLAG, d); check("R3 flag bit", d[3], 1'b1);
        check("R3 pin", ovf_flag, 1'b1);

        // R5 R6 random compare values
        for (int i = 0; i < 4; i++) cmp_test(20 + int'($urandom % 200));

        // R9 clear and set on the same edge
        m = 30 + int'($urandom % 50);
        halt();
        wr(A_MODE0, 16'h0002);
        wr(A_VAL0, 16'(m));
        wr(A_CNT, 16'h0000);
        wr(A_FLAG, 16'h000F);
        go();
        wait_n(m - 1);
        wr(A_FLAG, 16'h0001);
        check("R9 set wins", ch_flag[0], 1'b1);
        wr(A_FLAG, 16'h0001);
        check("R9 clear", ch_flag[0], 1'b0);

        // R4 capture
        m = 5 + int'($urandom % 40);
        halt();
        wr(A_MODE0, 16'h0009);
        wr(A_CNT, 16'h0000);
        wr(A_FLAG, 16'h000F);
        go();
        wait_n(m);
        cap[0] = 1'b1;
        wait_n(3);
        rd(A_VAL0, d);
        check("R4 rise capture", d, 16'(m + 2));
        check("R4 rise flag", ch_flag[0], 1'b1);
        wr(A_MODE0, 16'h0011);
        wr(A_FLAG, 16'h0001);
        rd(A_CNT, d);
        m = d;
        cap[0] = 1'b0;
        wait_n(3);
        rd(A_VAL0, d);
        check("R4 fall capture", d, 16'(m + 2));
        wr(A_FLAG, 16'h0001);
        rd(A_VAL0, d);
        m = d;
        cap[0] = 1'b1;
        wait_n(6);
        rd(A_VAL0, d);
        check("R4 rise ignored value", d, 16'(m));
        check("R4 rise ignored flag", ch_flag[0], 1'b0);

        // R7 PWM random widths and duties
        for (int i = 0; i < 4; i++) begin
            m = int'($urandom % 4);
            pwm_test(m, int'($urandom % (1 << (8 + m))));
        end
        pwm_test(0, 0);
        halt();
        wr(A_MODE0 + 4'd1, 16'h0084);
        wr(A_VAL0 + 4'd1, 16'h0100);
        wr(A_CNT, 16'hFFF0);
        go();
        wait_n(16);
        check("R7 16b rollover low", ch_out[1], 1'b0);
        wait_n(255);
        check("R7 16b before match", ch_out[1], 1'b0);
        wait_n(1);
        check("R7 16b high at match", ch_out[1], 1'b1);

        // R8 frequency output
        for (int i = 0; i < 3; i++) frq_test(2 + int'($urandom % 40), int'($urandom % 256));

        // R10 watchdog kicks and expiry
        do_reset();
        go();
        wr(A_WD, 16'h0201);
        wr(A_CNT, 16'h0000);
        wr(A_VAL0 + 4'd2, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            wait_n(200);
            wr(A_VAL0 + 4'd2, 16'h0000);
        end
        check("R10 kicked no reset", wd_rst, 1'b0);
        wr(A_CNT, 16'h0000);
        wr(A_VAL0 + 4'd2, 16'h0000);
        wait_n(16'h1FF);
        check("R10 before match", wd_rst, 1'b0);
        wait_n(1);
        check("R10 fires at match", wd_rst, 1'b1);
        wait_n(5);
        check("R10 sticky", wd_rst, 1'b1);

        // R11 disable is permanent
        do_reset();
        wr(A_WD, 16'h0200);
        wr(A_WD, 16'h0201);
        rd(A_WD, d); check("R11 stays disabled", d, 16'h0200);
        go();
        wr(A_CNT, 16'hFEF0);
        wait_n(400);
        check("R11 no reset", wd_rst, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule